// File: doc/BRIEF.md
# Quad Wiper Command Decoder and Setting Store

This block sits behind a two-wire serial protocol engine and serves a bank of four wiper counters. Once the engine has matched the device address, it hands the block the received bytes one at a time. The first byte of a frame is a command. Its upper nibble is the operation, the next two bits pick one of four stored settings, and the lowest two bits pick one of four wipers. Depending on the command, the block returns a byte for the engine to shift out, waits for one data byte, or acts on its own when the frame closes.

Each wiper has four 6-bit stored settings, held in ordinary flops. The block can move values between the stored settings and the wiper counters, either for one wiper or for all four at once. It can also switch the engine into single-step mode for one wiper. Any change to a stored setting starts a timed busy interval that models a slow nonvolatile write. During that interval, new frames are not served. A write-protect input, when low, blocks every change to the stored settings.

Top module: `pot_cmd_ctrl`

## Requirements
- R1: After reset, stored setting s of wiper w holds (RST_BASE + 4*w + s) mod 64. Exactly one load pulse then reaches all four wipers (ld_en_o = 1111), each carrying its setting 0. Busy, read-valid and step mode are all low.
- R2: A command byte carries the opcode in bits 7:4, the setting index in bits 3:2 and the wiper index in bits 1:0. Opcode 1001 asserts rd_vld_o from the cycle after the command byte until the frame closes, with rd_data_o = {2'b00, wiper value} sampled when the command byte arrives.
- R3: Opcode 1011 returns {2'b00, stored setting} of the selected wiper and index, with the same timing as R2.
- R4: Opcode 1010 followed by a data byte loads data bits 5:0 into the selected wiper. The load is a single pulse in the cycle after the frame closes, and bits 7:6 are dropped. If the frame closes before the data byte arrives, nothing is loaded.
- R5: Opcode 1100 followed by a data byte stores data bits 5:0 in the selected setting when the frame closes, and starts the busy interval.
- R6: Opcode 1101 loads the selected setting into its wiper when the frame closes. No data byte is used and no busy interval starts.
- R7: Opcode 1110 copies the wiper's current value into the selected setting when the frame closes, and starts the busy interval.
- R8: Opcode 0001 loads setting index s of every wiper into that wiper in one pulse (ld_en_o = 1111). The wiper field is ignored.
- R9: Opcode 1000 copies every wiper's value into its own setting s when the frame closes, and starts the busy interval.
- R10: Opcode 0010 raises step_mode_o, with step_sel_o set to the wiper field, from the cycle after the command byte until the frame closes. While in step mode, received bytes change nothing.
- R11: While wp_n_i is low at frame close, commands 1100, 1110 and 1000 change no stored setting and start no busy interval. Wiper loads are still carried out.
- R12: busy_o is high for exactly BUSY_CYC cycles, starting in the cycle after the closing stop. A frame opened while busy is ignored completely: it produces no read data, no step mode and no load.
- R13: Any other opcode is accepted but changes no wiper, no stored setting and no busy state.
- R14: If a new frame opens before the current one closes, the pending operation of the current frame is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_open_i | input | 1 | One-cycle pulse: the address matched and a frame begins |
| frm_close_i | input | 1 | One-cycle pulse: a stop condition ended the frame |
| rx_vld_i | input | 1 | One-cycle pulse: rx_byte_i holds a received byte |
| rx_byte_i | input | 8 | Received byte |
| wp_n_i | input | 1 | Low blocks all changes to stored settings |
| wpr_i | input | 24 | Current values of the four wiper counters, wiper w at bits 6w+5:6w |
| rd_vld_o | output | 1 | Read byte ready for the engine |
| rd_data_o | output | 8 | Read byte |
| busy_o | output | 1 | Modelled nonvolatile write in progress |
| step_mode_o | output | 1 | Engine may step the selected wiper |
| step_sel_o | output | 2 | Wiper selected for stepping |
| ld_en_o | output | 4 | Per-wiper load pulse |
| ld_val_o | output | 24 | Load values, wiper w at bits 6w+5:6w |

## Verification
The checks assume that the engine behaves as a well-formed source. frm_open_i, frm_close_i and rx_vld_i are single-cycle pulses that never coincide, and a close only ever follows an open. Under those conditions the checks expect loads only right after a close or at the reset recall, busy rising only after a close, and read and step outputs never active together or while busy. The stimulus drives each pulse for exactly one cycle on the falling clock edge, one event at a time, and always waits for busy to drop before starting the next frame, except in the deliberate busy-window test.

// File: rtl/potctl_pkg.sv
package potctl_pkg;
  localparam logic [3:0] OP_GDR2W = 4'b0001;
  localparam logic [3:0] OP_STEP  = 4'b0010;
  localparam logic [3:0] OP_GW2DR = 4'b1000;
  localparam logic [3:0] OP_RDW   = 4'b1001;
  localparam logic [3:0] OP_WRW   = 4'b1010;
  localparam logic [3:0] OP_RDD   = 4'b1011;
  localparam logic [3:0] OP_WRD   = 4'b1100;
  localparam logic [3:0] OP_D2W   = 4'b1101;
  localparam logic [3:0] OP_W2D   = 4'b1110;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_READ, ST_STEP, ST_HOLD
  } fsm_st_e;
endpackage

// File: rtl/pot_cmd_fsm.sv
module pot_cmd_fsm
  import potctl_pkg::*;
#(
  parameter int WW = 6,
  parameter int PW = 2,
  parameter int RW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          busy_i,
  input  logic          frm_open_i,
  input  logic          frm_close_i,
  input  logic          rx_vld_i,
  input  logic [7:0]    rx_byte_i,
  input  logic [WW-1:0] rd_wpr_i,
  input  logic [WW-1:0] rd_dr_i,
  output logic          rd_vld_o,
  output logic [7:0]    rd_data_o,
  output logic          step_mode_o,
  output logic [3:0]    op_o,
  output logic [RW-1:0] reg_o,
  output logic [PW-1:0] pot_o,
  output logic [WW-1:0] dat_o,
  output logic          cmt_o
);
  localparam int PADW = 8 - WW;

  fsm_st_e       st_q, st_d;
  logic [3:0]    op_q, op_d;
  logic [RW-1:0] reg_q, reg_d;
  logic [PW-1:0] pot_q, pot_d;
  logic [WW-1:0] dat_q, dat_d;
  logic [7:0]    rd_q, rd_d;
  logic          pend_q, pend_d;
  logic          cmt;

  always_comb begin
    st_d   = st_q;
    op_d   = op_q;
    reg_d  = reg_q;
    pot_d  = pot_q;
    dat_d  = dat_q;
    rd_d   = rd_q;
    pend_d = pend_q;
    cmt    = 1'b0;
    if (st_q == ST_IDLE) begin
      if (frm_open_i && !busy_i) begin
        st_d   = ST_CMD;
        pend_d = 1'b0;
      end
    end else if (frm_close_i) begin
      st_d   = ST_IDLE;
      cmt    = pend_q;
      pend_d = 1'b0;
    end else if (frm_open_i) begin
      st_d   = ST_CMD;
      pend_d = 1'b0;
    end else if (rx_vld_i) begin
      case (st_q)
        ST_CMD: begin
          op_d  = rx_byte_i[7:4];
          reg_d = rx_byte_i[PW +: RW];
          pot_d = rx_byte_i[PW-1:0];
          case (rx_byte_i[7:4])
            OP_RDW: begin
              st_d = ST_READ;
              rd_d = {{PADW{1'b0}}, rd_wpr_i};
            end
            OP_RDD: begin
              st_d = ST_READ;
              rd_d = {{PADW{1'b0}}, rd_dr_i};
            end
            OP_WRW, OP_WRD: st_d = ST_DATA;
            OP_D2W, OP_W2D, OP_GDR2W, OP_GW2DR: begin
              st_d   = ST_HOLD;
              pend_d = 1'b1;
            end
            OP_STEP: st_d = ST_STEP;
            default: st_d = ST_HOLD;
          endcase
        end
        ST_DATA: begin
          dat_d  = rx_byte_i[WW-1:0];
          pend_d = 1'b1;
          st_d   = ST_HOLD;
        end
        default: st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      op_q   <= '0;
      reg_q  <= '0;
      pot_q  <= '0;
      dat_q  <= '0;
      rd_q   <= '0;
      pend_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      op_q   <= op_d;
      reg_q  <= reg_d;
      pot_q  <= pot_d;
      dat_q  <= dat_d;
      rd_q   <= rd_d;
      pend_q <= pend_d;
    end
  end

  assign rd_vld_o    = (st_q == ST_READ);
  assign rd_data_o   = rd_q;
  assign step_mode_o = (st_q == ST_STEP);
  assign op_o        = op_q;
  assign reg_o       = reg_q;
  assign pot_o       = pot_q;
  assign dat_o       = dat_q;
  assign cmt_o       = cmt;
endmodule

// File: rtl/pot_dr_bank.sv
module pot_dr_bank #(
  parameter int NPOT     = 4,
  parameter int NREG     = 4,
  parameter int WW       = 6,
  parameter int RST_BASE = 8,
  localparam int RW      = $clog2(NREG)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NPOT-1:0]                we_i,
  input  logic [RW-1:0]                  idx_i,
  input  logic [NPOT-1:0][WW-1:0]        wval_i,
  output logic [NPOT-1:0][NREG-1:0][WW-1:0] dr_o
);
  for (genvar p = 0; p < NPOT; p++) begin : g_pot
    for (genvar r = 0; r < NREG; r++) begin : g_reg
      localparam int RVI = (RST_BASE + p * NREG + r) % (1 << WW);
      localparam logic [WW-1:0] RV = RVI[WW-1:0];
      logic en;
      assign en = we_i[p] && (idx_i == RW'(r));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  dr_o[p][r] <= RV;
        else if (en) dr_o[p][r] <= wval_i[p];
      end
    end
  end
endmodule

// File: rtl/pot_nv_timer.sv
module pot_nv_timer #(
  parameter int BUSY_CYC = 50000,
  localparam int CW      = $clog2(BUSY_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (start_i)          cnt_d = CW'(BUSY_CYC);
    else if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
    else                  cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/pot_cmd_ctrl.sv
module pot_cmd_ctrl
  import potctl_pkg::*;
#(
  parameter int NPOT     = 4,
  parameter int NREG     = 4,
  parameter int WW       = 6,
  parameter int BUSY_CYC = 50000,
  parameter int RST_BASE = 8,
  localparam int PW      = $clog2(NPOT),
  localparam int RW      = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frm_open_i,
  input  logic               frm_close_i,
  input  logic               rx_vld_i,
  input  logic [7:0]         rx_byte_i,
  input  logic               wp_n_i,
  input  logic [NPOT*WW-1:0] wpr_i,
  output logic               rd_vld_o,
  output logic [7:0]         rd_data_o,
  output logic               busy_o,
  output logic               step_mode_o,
  output logic [PW-1:0]      step_sel_o,
  output logic [NPOT-1:0]    ld_en_o,
  output logic [NPOT*WW-1:0] ld_val_o
);
  logic rs1_q, rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q   <= 1'b0;
      rst_n_s <= 1'b0;
    end else begin
      rs1_q   <= 1'b1;
      rst_n_s <= rs1_q;
    end
  end

  logic [NPOT-1:0][WW-1:0]            wpr;
  logic [NPOT-1:0][NREG-1:0][WW-1:0]  dr;
  for (genvar i = 0; i < NPOT; i++) begin : g_unpack
    assign wpr[i] = wpr_i[i*WW +: WW];
  end

  logic [3:0]    op;
  logic [RW-1:0] ridx;
  logic [PW-1:0] pidx;
  logic [WW-1:0] dat;
  logic          cmt;
  logic [WW-1:0] rd_wpr, rd_dr;

  assign rd_wpr = wpr[rx_byte_i[PW-1:0]];
  assign rd_dr  = dr[rx_byte_i[PW-1:0]][rx_byte_i[PW +: RW]];

  pot_cmd_fsm #(.WW(WW), .PW(PW), .RW(RW)) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .busy_i      (busy_o),
    .frm_open_i  (frm_open_i),
    .frm_close_i (frm_close_i),
    .rx_vld_i    (rx_vld_i),
    .rx_byte_i   (rx_byte_i),
    .rd_wpr_i    (rd_wpr),
    .rd_dr_i     (rd_dr),
    .rd_vld_o    (rd_vld_o),
    .rd_data_o   (rd_data_o),
    .step_mode_o (step_mode_o),
    .op_o        (op),
    .reg_o       (ridx),
    .pot_o       (pidx),
    .dat_o       (dat),
    .cmt_o       (cmt)
  );
  assign step_sel_o = pidx;

  logic                    rcl_q;
  logic [NPOT-1:0]         ld_en_d, ld_en_q;
  logic [NPOT-1:0][WW-1:0] ld_val_d, ld_val_q;
  logic [NPOT-1:0]         dr_we;
  logic [NPOT-1:0][WW-1:0] dr_wval;
  logic                    bz_start;

  always_comb begin
    ld_en_d  = '0;
    ld_val_d = ld_val_q;
    dr_we    = '0;
    dr_wval  = wpr;
    bz_start = 1'b0;
    if (rcl_q) begin
      ld_en_d = '1;
      for (int i = 0; i < NPOT; i++) ld_val_d[i] = dr[i][0];
    end else if (cmt) begin
      case (op)
        OP_WRW: begin
          ld_en_d[pidx]  = 1'b1;
          ld_val_d[pidx] = dat;
        end
        OP_D2W: begin
          ld_en_d[pidx]  = 1'b1;
          ld_val_d[pidx] = dr[pidx][ridx];
        end
        OP_GDR2W: begin
          ld_en_d = '1;
          for (int i = 0; i < NPOT; i++) ld_val_d[i] = dr[i][ridx];
        end
        OP_WRD: begin
          dr_we[pidx]   = wp_n_i;
          dr_wval[pidx] = dat;
          bz_start      = wp_n_i;
        end
        OP_W2D: begin
          dr_we[pidx] = wp_n_i;
          bz_start    = wp_n_i;
        end
        OP_GW2DR: begin
          dr_we    = {NPOT{wp_n_i}};
          bz_start = wp_n_i;
        end
        default: bz_start = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      rcl_q   <= 1'b1;
      ld_en_q <= '0;
    end else begin
      rcl_q   <= 1'b0;
      ld_en_q <= ld_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      ld_val_q <= '0;
    end else begin
      for (int i = 0; i < NPOT; i++)
        if (ld_en_d[i]) ld_val_q[i] <= ld_val_d[i];
    end
  end

  assign ld_en_o = ld_en_q;
  for (genvar i = 0; i < NPOT; i++) begin : g_pack
    assign ld_val_o[i*WW +: WW] = ld_val_q[i];
  end

  pot_dr_bank #(.NPOT(NPOT), .NREG(NREG), .WW(WW), .RST_BASE(RST_BASE)) u_bank (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .we_i   (dr_we),
    .idx_i  (ridx),
    .wval_i (dr_wval),
    .dr_o   (dr)
  );

  pot_nv_timer #(.BUSY_CYC(BUSY_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .start_i (bz_start),
    .busy_o  (busy_o)
  );
endmodule

// File: rtl/pot_cmd_ctrl_chk.sv
module pot_cmd_ctrl_chk #(
  parameter int NPOT = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            frm_close_i,
  input logic            busy_o,
  input logic            rd_vld_o,
  input logic [1:0]      rd_hi,
  input logic            step_mode_o,
  input logic [NPOT-1:0] ld_en_o
);
  logic [1:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cyc_q <= '0;
    else if (cyc_q != 2'd2) cyc_q <= cyc_q + 1'b1;
  end

  // R12
  busy_after_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(frm_close_i));

  // R1 R4
  load_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ld_en_o != '0) && (cyc_q == 2'd2)) |-> $past(frm_close_i));

  // R8
  load_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld_en_o) || (ld_en_o == '1));

  // R10
  read_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_vld_o && step_mode_o));

  // R12
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> (!rd_vld_o && !step_mode_o));

  // R2
  read_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> (rd_hi == 2'b00));
endmodule

bind pot_cmd_ctrl pot_cmd_ctrl_chk #(.NPOT(NPOT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n_s),
  .frm_close_i (frm_close_i),
  .busy_o      (busy_o),
  .rd_vld_o    (rd_vld_o),
  .rd_hi       (rd_data_o[7:6]),
  .step_mode_o (step_mode_o),
  .ld_en_o     (ld_en_o)
);

// File: tb/sim_pot_cmd_ctrl.sv
module sim_pot_cmd_ctrl;
  localparam int TCK     = 10;
  localparam int TB_BUSY = 20;

  logic        clk, rst_n, frm_open, frm_close, rx_vld, wp_n;
  logic [7:0]  rx_byte;
  logic [23:0] wpr;
  logic        rd_vld, busy, step_mode;
  logic [7:0]  rd_data;
  logic [1:0]  step_sel;
  logic [3:0]  ld_en;
  logic [23:0] ld_val;

  int n_run  = 0;
  int n_fail = 0;
  logic [5:0] mdl [4][4];
  logic [5:0] wv [4];

  pot_cmd_ctrl #(.BUSY_CYC(TB_BUSY), .RST_BASE(8)) u0 (
    .clk(clk), .rst_n(rst_n), .frm_open_i(frm_open), .frm_close_i(frm_close),
    .rx_vld_i(rx_vld), .rx_byte_i(rx_byte), .wp_n_i(wp_n), .wpr_i(wpr),
    .rd_vld_o(rd_vld), .rd_data_o(rd_data), .busy_o(busy),
    .step_mode_o(step_mode), .step_sel_o(step_sel),
    .ld_en_o(ld_en), .ld_val_o(ld_val)
  );

  initial begin
    clk = 1'b0;
    forever #(TCK/2) clk = ~clk;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic set_wpr();
    wpr = {wv[3], wv[2], wv[1], wv[0]};
  endtask

  task automatic open_f();
    frm_open = 1'b1; @(negedge clk); frm_open = 1'b0;
  endtask

  task automatic send_b(input logic [7:0] b);
    rx_vld = 1'b1; rx_byte = b; @(negedge clk); rx_vld = 1'b0;
  endtask

  task automatic close_f();
    frm_close = 1'b1; @(negedge clk); frm_close = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 200 && busy; k++) @(negedge clk);
  endtask

  task automatic read_dr(input int p, input int r, output logic [7:0] v);
    open_f();
    send_b({4'b1011, 2'(r), 2'(p)});
    v = rd_vld ? rd_data : 8'hEE;
    close_f();
  endtask

  task automatic t_reset();
    int k;
    for (k = 0; k < 8 && ld_en == 4'b0; k++) @(negedge clk);
    chk("R1 recall enables", ld_en, 4'hF);
    chk("R1 recall values", ld_val, {mdl[3][0], mdl[2][0], mdl[1][0], mdl[0][0]});
    chk("R1 busy low", busy, 0);
    chk("R1 read/step low", {rd_vld, step_mode}, 0);
    @(negedge clk);
    chk("R1 single pulse", ld_en, 0);
  endtask

  task automatic t_rd_wiper();
    wv[0] = 6'd1; wv[1] = 6'd62; wv[2] = 6'd5; wv[3] = 6'd33; set_wpr();
    open_f();
    send_b(8'b1001_00_10);
    chk("R2 read valid", rd_vld, 1);
    chk("R2 wiper value", rd_data, {2'b00, 6'd5});
    close_f();
    chk("R2 read ends at close", rd_vld, 0);
    chk("R2 no load", ld_en, 0);
  endtask

  task automatic t_rd_dr();
    logic [7:0] v;
    read_dr(3, 2, v);
    chk("R3 stored value", v, {2'b00, mdl[3][2]});
  endtask

  task automatic t_wr_wiper();
    open_f(); send_b(8'b1010_00_01); send_b(8'hC0 | 8'd45); close_f();
    chk("R4 load enable", ld_en, 4'b0010);
    chk("R4 load value", ld_val[11:6], 6'd45);
    chk("R4 no busy", busy, 0);
    open_f(); send_b(8'b1010_00_01); close_f();
    chk("R4 no data no load", ld_en, 0);
  endtask

  task automatic t_wr_dr();
    int n = 0;
    logic [7:0] v;
    open_f(); send_b(8'b1100_01_10); send_b(8'd50); close_f();
    for (int k = 0; k < 200 && busy; k++) begin n++; @(negedge clk); end
    chk("R12 busy length", n, TB_BUSY);
    mdl[2][1] = 6'd50;
    read_dr(2, 1, v);
    chk("R5 stored", v, 8'd50);
  endtask

  task automatic t_d2w();
    open_f(); send_b(8'b1101_11_00); close_f();
    chk("R6 load enable", ld_en, 4'b0001);
    chk("R6 load value", ld_val[5:0], mdl[0][3]);
    chk("R6 no busy", busy, 0);
  endtask

  task automatic t_w2d();
    logic [7:0] v;
    wv[1] = 6'd39; set_wpr();
    open_f(); send_b(8'b1110_00_01); close_f();
    chk("R7 busy", busy, 1);
    chk("R7 no load", ld_en, 0);
    wait_idle();
    mdl[1][0] = 6'd39;
    read_dr(1, 0, v);
    chk("R7 stored", v, 8'd39);
  endtask

  task automatic t_g2w();
    open_f(); send_b(8'b0001_10_11); close_f();
    chk("R8 all enables", ld_en, 4'hF);
    chk("R8 values", ld_val, {mdl[3][2], mdl[2][2], mdl[1][2], mdl[0][2]});
  endtask

  task automatic t_gw2d();
    logic [7:0] v;
    wv[0] = 6'd11; wv[1] = 6'd22; wv[2] = 6'd44; wv[3] = 6'd63; set_wpr();
    open_f(); send_b(8'b1000_11_00); close_f();
    chk("R9 busy", busy, 1);
    wait_idle();
    for (int p = 0; p < 4; p++) begin
      mdl[p][3] = wv[p];
      read_dr(p, 3, v);
      chk("R9 stored", v, {2'b00, wv[p]});
    end
    read_dr(2, 2, v);
    chk("R9 other index kept", v, {2'b00, mdl[2][2]});
  endtask

  task automatic t_step();
    open_f(); send_b(8'b0010_00_11);
    chk("R10 step on", step_mode, 1);
    chk("R10 step select", step_sel, 2'd3);
    send_b(8'hFF);
    chk("R10 byte ignored", ld_en, 0);
    close_f();
    chk("R10 step off", step_mode, 0);
    chk("R10 no load", ld_en, 0);
  endtask

  task automatic t_wp();
    logic [7:0] v;
    wp_n = 1'b0;
    open_f(); send_b(8'b1100_01_00); send_b(8'd7); close_f();
    chk("R11 write blocked no busy", busy, 0);
    read_dr(0, 1, v);
    chk("R11 write blocked", v, {2'b00, mdl[0][1]});
    open_f(); send_b(8'b1110_10_11); close_f();
    chk("R11 copy blocked no busy", busy, 0);
    read_dr(3, 2, v);
    chk("R11 copy blocked", v, {2'b00, mdl[3][2]});
    open_f(); send_b(8'b1010_00_11); send_b(8'd17); close_f();
    chk("R11 wiper load allowed", ld_en, 4'b1000);
    chk("R11 wiper value", ld_val[23:18], 6'd17);
    wp_n = 1'b1;
  endtask

  task automatic t_busy();
    open_f(); send_b(8'b1110_01_00); close_f();
    mdl[0][1] = wv[0];
    chk("R12 busy set", busy, 1);
    open_f(); send_b(8'b1001_00_00);
    chk("R12 read ignored", rd_vld, 0);
    close_f();
    open_f(); send_b(8'b1010_00_00); send_b(8'd3); close_f();
    chk("R12 write ignored", ld_en, 0);
    wait_idle();
  endtask

  task automatic t_undef();
    logic [7:0] v;
    open_f(); send_b(8'b0000_00_00); close_f();
    chk("R13 op0000 no load", ld_en, 0);
    chk("R13 op0000 no busy", busy, 0);
    open_f(); send_b(8'b1111_11_11); send_b(8'd9); close_f();
    chk("R13 op1111 no load", ld_en, 0);
    chk("R13 op1111 no busy", busy, 0);
    read_dr(3, 3, v);
    chk("R13 store kept", v, {2'b00, mdl[3][3]});
  endtask

  task automatic t_restart();
    open_f(); send_b(8'b1010_00_10); send_b(8'd21);
    open_f(); send_b(8'b0000_00_00); close_f();
    chk("R14 pending dropped", ld_en, 0);
    open_f(); send_b(8'b1101_00_01);
    open_f(); close_f();
    chk("R14 transfer dropped", ld_en, 0);
  endtask

  initial begin
    rst_n = 1'b0; frm_open = 1'b0; frm_close = 1'b0; rx_vld = 1'b0;
    rx_byte = 8'h00; wp_n = 1'b1;
    for (int p = 0; p < 4; p++) begin
      wv[p] = 6'(p);
      for (int r = 0; r < 4; r++) mdl[p][r] = 6'(8 + 4 * p + r);
    end
    set_wpr();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rd_wiper();
    t_rd_dr();
    t_wr_wiper();
    t_wr_dr();
    t_d2w();
    t_w2d();
    t_g2w();
    t_gw2d();
    t_step();
    t_wp();
    t_busy();
    t_undef();
    t_restart();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(TCK * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule